// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a cycle timer that sits beside a processor core. It holds a 32-bit count register and a 32-bit control register, both reachable over a small register bus with an address, a write strobe, write data and combinational read data. While the timer runs, the count advances by one on every clock. A comparator watches the low 28 bits of the count against a 28-bit period held in the control register.

When the comparator sees equality, the block acts according to a 2-bit mode. It can reload the count with zero, freeze it at the period and stop, or let it keep running. In every running mode, a match can latch a sticky pending flag. Only a software write to the control register clears that flag. The block drives the flag out directly. It also drives an interrupt request that is gated by an external tick-exception enable from the core.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the control register reads 0, the pending output and the interrupt request are low, and the timer is stopped.
- R2: Bus address 0 selects the control register and address 1 selects the count register. Reads are combinational. In the control register, bits 31:30 are the mode (00 off, 01 restart, 10 single-run, 11 continuous), bit 29 is interrupt enable, bit 28 is pending, and bits 27:0 are the period.
- R3: A match compares only count bits 27:0 with the period, so count bits 31:28 are ignored. A count of 0x1000_0006 matches a period of 6.
- R4: In restart mode, a match reloads the count with 0 on the next clock and counting continues. With period P the count cycles through 0..P.
- R5: In single-run mode, a match stops the timer and holds the count at the period value, zero-extended. Later reads return that value.
- R6: In continuous mode, a match does not disturb the count, which keeps incrementing by one every clock.
- R7: A match while the timer runs with interrupt enable set raises pending on the next clock. Pending then stays high until a control write. With interrupt enable clear, a match leaves pending low.
- R8: A write to the control register always clears pending, whatever value bit 28 of the write data holds. In the write cycle the count holds its value.
- R9: The interrupt request is high exactly while pending is high and the tick-exception enable input is high.
- R10: A count write loads the written value. If the timer runs, counting resumes from that value. While the timer is off or stopped, the count keeps its last value.
- R11: A control write that selects continuous mode while the full count already equals the new period leaves the timer stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| tee_i | input | 1 | Tick-exception enable from the core |
| pending_o | output | 1 | Sticky match-pending flag |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench preloads the count with bit 28 set and places the period in the low bits. A design that compares all 32 bits would then never raise pending. It writes the control register with bit 28 set in the data, so a design that copies the written bit would leave pending high. It lets single-run mode sit well past its match, so a design that restarts or keeps counting would read back a value other than the period. It also enters continuous mode with the count already at the period, where a design that starts counting would show a moving count.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic [1:0] {
      TM_OFF     = 2'b00,
      TM_RESTART = 2'b01,
      TM_SINGLE  = 2'b10,
      TM_CONT    = 2'b11
   } tick_mode_e;
endpackage

// File: rtl/tick_cmp.sv
module tick_cmp #(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic [DATA_W-1:0]   cnt_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                low_eq_o,
   output logic                full_eq_o
);
   generate
      if (PERIOD_W == DATA_W) begin : g_same
         assign low_eq_o  = (cnt_i == period_i);
         assign full_eq_o = (cnt_i == period_i);
      end else begin : g_slice
         localparam int HI_W = DATA_W - PERIOD_W;
         assign low_eq_o  = (cnt_i[PERIOD_W-1:0] == period_i);
         assign full_eq_o = (cnt_i == {{HI_W{1'b0}}, period_i});
      end
   endgenerate
endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
   import tick_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic                hit_i,
   output tick_mode_e          mode_o,
   output logic                ie_o,
   output logic                ip_o,
   output logic [PERIOD_W-1:0] period_o,
   output logic [DATA_W-1:0]   value_o
);
   localparam int MODE_HI = DATA_W - 1;
   localparam int MODE_LO = DATA_W - 2;
   localparam int IE_BIT  = DATA_W - 3;

   tick_mode_e          mode_q;
   logic                ie_q, ip_q;
   logic [PERIOD_W-1:0] period_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= TM_OFF;
         ie_q     <= 1'b0;
         ip_q     <= 1'b0;
         period_q <= '0;
      end else if (wr_i) begin
         mode_q   <= tick_mode_e'(wdata_i[MODE_HI:MODE_LO]);
         ie_q     <= wdata_i[IE_BIT];
         ip_q     <= 1'b0;
         period_q <= wdata_i[PERIOD_W-1:0];
      end else if (hit_i && ie_q && !ip_q) begin
         ip_q <= 1'b1;
      end
   end

   assign mode_o   = mode_q;
   assign ie_o     = ie_q;
   assign ip_o     = ip_q;
   assign period_o = period_q;
   assign value_o  = {mode_q, ie_q, ip_q, period_q};

   assert_pend_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ip_q) |-> $past(hit_i && ie_q));
   assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ip_q && !wr_i) |=> ip_q);
   assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !ip_q);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
   import tick_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cnt_wr_i,
   input  logic                mode_wr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  tick_mode_e          mode_i,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic                eq_i,
   input  logic                wr_full_eq_i,
   output logic [DATA_W-1:0]   cnt_o,
   output logic                run_o,
   output logic                hit_o
);
   localparam int HI_W = DATA_W - PERIOD_W;

   logic [DATA_W-1:0] cnt_q;
   logic              run_q;
   tick_mode_e        new_mode;

   assign new_mode = tick_mode_e'(wdata_i[DATA_W-1:DATA_W-2]);
   assign hit_o    = run_q && eq_i && !cnt_wr_i && !mode_wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (cnt_wr_i) begin
         cnt_q <= wdata_i;
      end else if (mode_wr_i) begin
         run_q <= (new_mode != TM_OFF) && !(new_mode == TM_CONT && wr_full_eq_i);
      end else if (run_q) begin
         if (hit_o && mode_i == TM_RESTART) begin
            cnt_q <= '0;
         end else if (hit_o && mode_i == TM_SINGLE) begin
            cnt_q <= {{HI_W{1'b0}}, period_i};
            run_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign run_o = run_q;

   assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && mode_i == TM_RESTART) |=> (cnt_q == '0));
   assert_single_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && mode_i == TM_SINGLE) |=> (!run_q && cnt_q == {{HI_W{1'b0}}, $past(period_i)}));
   assert_cont_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode_i == TM_CONT && !cnt_wr_i && !mode_wr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
   assert_stopped_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cnt_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int PERIOD_W   = 28,
   parameter int ADDR_W     = 4,
   parameter int MODE_ADDR  = 0,
   parameter int COUNT_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tee_i,
   output logic              pending_o,
   output logic              irq_o
);
   generate
      if (PERIOD_W != DATA_W - 4) begin : g_bad_period
         $error("tick_timer: PERIOD_W must leave exactly four control bits");
      end
      if (MODE_ADDR == COUNT_ADDR) begin : g_bad_addr
         $error("tick_timer: register addresses must differ");
      end
   endgenerate

   logic                sel_mode, sel_count, mode_wr, cnt_wr;
   tick_mode_e          mode;
   logic                ie, ip, eq, wr_full_eq, unused_eq, run, hit;
   logic [PERIOD_W-1:0] period;
   logic [DATA_W-1:0]   ctrl_val, cnt;

   assign sel_mode  = (bus_addr == ADDR_W'(MODE_ADDR));
   assign sel_count = (bus_addr == ADDR_W'(COUNT_ADDR));
   assign mode_wr   = bus_we && sel_mode;
   assign cnt_wr    = bus_we && sel_count;

   tick_ctrl_reg #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_i(mode_wr), .wdata_i(bus_wdata), .hit_i(hit),
      .mode_o(mode), .ie_o(ie), .ip_o(ip), .period_o(period), .value_o(ctrl_val));

   tick_cmp #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_cmp_run (
      .cnt_i(cnt), .period_i(period), .low_eq_o(eq), .full_eq_o(unused_eq));

   tick_cmp #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_cmp_wr (
      .cnt_i(cnt), .period_i(bus_wdata[PERIOD_W-1:0]), .low_eq_o(),
      .full_eq_o(wr_full_eq));

   tick_counter #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_wr_i(cnt_wr), .mode_wr_i(mode_wr),
      .wdata_i(bus_wdata), .mode_i(mode), .period_i(period), .eq_i(eq),
      .wr_full_eq_i(wr_full_eq), .cnt_o(cnt), .run_o(run), .hit_o(hit));

   always_comb begin
      bus_rdata = '0;
      if (sel_mode)       bus_rdata = ctrl_val;
      else if (sel_count) bus_rdata = cnt;
   end

   assign pending_o = ip;
   assign irq_o     = ip && tee_i;

   assert_irq_needs_tee_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (tee_i && pending_o));
   assert_off_mode_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_OFF) |-> !run);
   assert_no_ie_no_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie && !ip && !mode_wr) |=> !ip);
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
   localparam logic [31:0] M_RESTART = 32'h4000_0000;
   localparam logic [31:0] M_SINGLE  = 32'h8000_0000;
   localparam logic [31:0] M_CONT    = 32'hC000_0000;
   localparam logic [31:0] F_IE      = 32'h2000_0000;
   localparam logic [31:0] F_IP      = 32'h1000_0000;
   localparam int K_RD = 0, K_PEND = 1, K_IRQ = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tee_i = 1'b0;
   logic        pending_o, irq_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];
   event     chk_ev;

   always #4 clk = ~clk;

   tick_timer u_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tee_i(tee_i),
      .pending_o(pending_o), .irq_o(irq_o));

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               K_PEND:  act = {31'b0, pending_o};
               K_IRQ:   act = {31'b0, irq_o};
               default: act = bus_rdata;
            endcase
            vectors++;
            if (act !== it.exp) begin
               miscompares++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [3:0] a, input logic [31:0] exp, input string tag);
      sb_item_t it;
      bus_addr = a;
      #0.1;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      -> chk_ev;
      #0.1;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      push(K_RD, a, exp, tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      rd(0, 32'h0, "R1");
      rd(1, 32'h0, "R1");
      push(K_PEND, 0, 0, "R1");
      push(K_IRQ, 0, 0, "R1");
      step(3);
      rd(1, 32'h0, "R1");

      // R10 disabled timer keeps the written count
      wr(1, 32'd100);
      rd(1, 32'd100, "R10");
      step(5);
      rd(1, 32'd100, "R10");

      // R4 restart, period 4, no interrupt enable
      wr(1, 32'd0);
      wr(0, M_RESTART | 32'd4);
      rd(0, M_RESTART | 32'd4, "R2");
      step(7);
      rd(1, 32'd2, "R4");
      step(3);
      rd(1, 32'd0, "R4");
      push(K_PEND, 0, 0, "R7");

      // R3/R6/R7/R9 continuous with upper count bit set
      wr(0, 32'h0);
      wr(1, 32'h1000_0003);
      wr(0, M_CONT | F_IE | 32'd6);
      step(2);
      rd(1, 32'h1000_0005, "R6");
      push(K_PEND, 0, 0, "R7");
      step(2);
      rd(1, 32'h1000_0007, "R6");
      push(K_PEND, 0, 1, "R3");
      push(K_IRQ, 0, 0, "R9");
      tee_i = 1'b1;
      push(K_IRQ, 0, 1, "R9");
      step(3);
      push(K_PEND, 0, 1, "R7");
      rd(1, 32'h1000_000A, "R6");
      rd(0, M_CONT | F_IE | F_IP | 32'd6, "R2");

      // R8 control write with bit 28 set still clears pending
      wr(0, M_CONT | F_IE | F_IP | 32'd6);
      push(K_PEND, 0, 0, "R8");
      push(K_IRQ, 0, 0, "R9");
      rd(1, 32'h1000_000A, "R8");
      rd(0, M_CONT | F_IE | 32'd6, "R8");

      // R5 single-run, period 3
      wr(0, 32'h0);
      wr(1, 32'd0);
      wr(0, M_SINGLE | F_IE | 32'd3);
      step(10);
      rd(1, 32'd3, "R5");
      push(K_PEND, 0, 1, "R5");
      push(K_IRQ, 0, 1, "R9");
      rd(0, M_SINGLE | F_IE | F_IP | 32'd3, "R5");
      wr(1, 32'd50);
      step(3);
      rd(1, 32'd50, "R10");

      // R11 continuous entered at the period stays stopped
      wr(0, 32'h0);
      wr(1, 32'd9);
      wr(0, M_CONT | 32'd9);
      step(4);
      rd(1, 32'd9, "R11");
      push(K_PEND, 0, 0, "R11");

      // R10 count write while running resumes from the new value
      wr(0, M_CONT | 32'h0FFF_FFFF);
      step(2);
      rd(1, 32'd11, "R10");
      wr(1, 32'd200);
      step(3);
      rd(1, 32'd203, "R10");

      step(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule